// File: doc/BRIEF.md
# MSI Event Queue Engine

The engine turns message-signalled interrupt writes into fixed-size records in memory-resident ring buffers. Each incoming write carries an MSI number, a 16-bit data value, the target address, the requester ID and a flag telling a 32-bit from a 64-bit address. The MSI number selects one entry of a mapping table. That entry says whether the MSI is armed, whether an earlier write is still waiting for software, and which event queue it feeds. An accepted write leaves the block one cycle later as a 64-byte record-write request. The request points at the queue's current tail slot. In the same step the tail advances and the queue's interrupt line rises.

Software reaches the mapping table, a clear register per MSI, a set and a clear control register per queue, the queue state, the tail and the head through one word-addressed register port. It drains a queue by consuming records and writing the head back. A queue whose ring has no room takes no record. It flags overflow and stays in an error state until software moves it back to idle.

Top module: `msi_eq_engine`

## Requirements
- R1: After reset every queue reads state 1 (idle), enable 0, overflow 0, head 0 and tail 0, every mapping entry reads 0, `q_irq` is all zero and `mem_wr_valid` is low.
- R2: An MSI is accepted when all of these hold: its mapping entry is valid, its pending bit is clear, its queue number Q lies in [FIRST_Q, FIRST_Q+NUM_Q), queue Q−FIRST_Q is enabled, and that queue is not in error. On the next cycle `mem_wr_valid` is high with `mem_wr_addr` = BASE_ADDR + (Q−FIRST_Q)·8192 + tail·64. The tail then reads one higher and the entry's pending bit (bit 62) reads 1.
- R3: Word k of the record sits at `mem_wr_data[64k+63:64k]`. Word 0 holds, from the top bit down: bit 63 = 0; bits 62:56 = type·8, where type is 0xB for a 32-bit and 0xF for a 64-bit MSI; bits 55:46 = 1; bits 45:32 = address bits 15:2; bits 31:16 = requester ID; bits 15:0 = MSI number. Word 1 holds address bits 63:16 in bits 63:16 and the MSI data in bits 15:0. Words 2 to 7 are zero.
- R4: An MSI that fails any condition of R2 produces no record and leaves the tail unchanged.
- R5: Writing an MSI's clear register with bit 62 set clears its pending bit. A write with bit 62 clear has no effect.
- R6: A mapping write stores the valid bit (bit 63) and the queue number (bits 5:0). Bit 62 of the written value is ignored, so pending cannot be set through the mapping register.
- R7: Writing bit 44 of a queue's control-set register enables the queue, and writing bit 44 of its control-clear register disables it. Writes without bit 44 leave the enable unchanged. Both control registers read back enable at bit 44 and overflow at bit 57.
- R8: Queue state reads one-hot: 1 idle, 2 active, 4 error. An accepted MSI makes the queue active, and `q_irq[i]` is high exactly while queue i is active. A head write that makes the head equal to the tail returns an active queue to idle.
- R9: If tail+1 (mod 128) equals the head when an MSI is accepted, no record is written and pending stays clear. Instead overflow is set (tail register bit 57) and the queue enters error. While the queue is in error, further MSIs to it are dropped.
- R10: Control-clear bit 47 moves a queue from error to idle, and control-clear bit 57 clears its overflow flag. Each bit acts independently of the other.
- R11: The tail wraps from 127 to 0. A record written from tail 127 goes to slot 127.
- R12: The register word address is {region[2:0], index[5:0]}. The regions are: 0 mapping, 1 MSI clear, 2 control set, 3 control clear, 4 state, 5 tail, 6 head. For a queue region the index is the local queue number. Reads are combinational, and writes act at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msi_valid | input | 1 | An MSI write is presented this cycle |
| msi_num | input | MSI_W | MSI number |
| msi_data | input | 16 | MSI data value |
| msi_addr | input | 64 | MSI target address |
| msi_rid | input | 16 | Requester ID |
| msi_is64 | input | 1 | 1 for a 64-bit address MSI |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register word address {region, index} |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data |
| mem_wr_valid | output | 1 | Record write request |
| mem_wr_addr | output | MEM_AW | Byte address of the record |
| mem_wr_data | output | 512 | Eight 64-bit record words |
| q_irq | output | NUM_Q | Per-queue interrupt, high while active |

## Verification
The bench builds the engine with 16 MSIs, 4 queues, FIRST_Q = 2 and a nonzero base address. With these values a mapping can point below, inside or above the queue window, and the subtraction of the first queue shows up in the record address. Small queue and MSI counts keep every table entry reachable from the register port. Tail and head are preloaded through the register port, so the full-ring and tail-wrap corners are reached in a few MSIs instead of a hundred.

// File: rtl/msi_eq_pkg.sv
package msi_eq_pkg;
    localparam int RING_IDX_W  = 7;
    localparam int REC_SHIFT   = 6;
    localparam int QUEUE_SHIFT = 13;
    localparam int REC_WORDS   = 8;
    localparam int REC_W       = REC_WORDS * 64;
    localparam int QNUM_W      = 6;
    localparam int REG_IDX_W   = 6;
    localparam int REG_RGN_W   = 3;
    localparam int REG_AW      = REG_RGN_W + REG_IDX_W;

    localparam int MAP_VALID_BIT = 63;
    localparam int MAP_PEND_BIT  = 62;
    localparam int CTL_EN_BIT    = 44;
    localparam int CTL_E2I_BIT   = 47;
    localparam int CTL_OVF_BIT   = 57;

    localparam logic [3:0] TYPE_MSI32 = 4'hB;
    localparam logic [3:0] TYPE_MSI64 = 4'hF;
    localparam logic [9:0] REC_LEN    = 10'd1;

    typedef enum logic [2:0] {
        QS_IDLE   = 3'b001,
        QS_ACTIVE = 3'b010,
        QS_ERROR  = 3'b100
    } qstate_e;

    typedef enum logic [2:0] {
        RG_MAP   = 3'd0,
        RG_PCLR  = 3'd1,
        RG_CSET  = 3'd2,
        RG_CCLR  = 3'd3,
        RG_STATE = 3'd4,
        RG_TAIL  = 3'd5,
        RG_HEAD  = 3'd6,
        RG_NONE  = 3'd7
    } rgn_e;

    typedef struct packed {
        logic              valid;
        logic              pend;
        logic [QNUM_W-1:0] qnum;
    } map_ent_t;

    function automatic logic [63:0] rec_word0(input logic is64, input logic [63:0] addr,
                                              input logic [15:0] rid, input logic [15:0] num);
        logic [3:0] typ;
        typ = is64 ? TYPE_MSI64 : TYPE_MSI32;
        return {1'b0, typ, 3'b000, REC_LEN, addr[15:2], rid, num};
    endfunction

    function automatic logic [63:0] rec_word1(input logic [63:0] addr, input logic [15:0] data);
        return {addr[63:16], data};
    endfunction
endpackage

// File: rtl/msi_map_table.sv
module msi_map_table
    import msi_eq_pkg::*;
#(
    parameter int NUM_MSI = 64,
    parameter int MSI_W   = $clog2(NUM_MSI)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MSI_W-1:0]     lk_num,
    output map_ent_t             lk_ent,
    input  logic                 set_pend,
    input  logic                 map_we,
    input  logic                 pclr_we,
    input  logic [REG_IDX_W-1:0] reg_idx,
    input  logic                 w_valid,
    input  logic                 w_pend,
    input  logic [QNUM_W-1:0]    w_qnum,
    output map_ent_t             rd_ent
);
    typedef struct packed {
        map_ent_t [NUM_MSI-1:0] ent;
    } map_st_t;

    map_st_t          st_d, st_q;
    logic             idx_ok;
    logic [MSI_W-1:0] ridx;

    assign idx_ok = (32'(reg_idx) < NUM_MSI);
    assign ridx   = reg_idx[MSI_W-1:0];

    always_comb begin
        st_d = st_q;
        if (set_pend)
            st_d.ent[lk_num].pend = 1'b1;
        if (map_we && idx_ok) begin
            st_d.ent[ridx].valid = w_valid;
            st_d.ent[ridx].qnum  = w_qnum;
        end
        if (pclr_we && idx_ok && w_pend)
            st_d.ent[ridx].pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lk_ent = st_q.ent[lk_num];
    assign rd_ent = idx_ok ? st_q.ent[ridx] : '0;

    for (genvar gi = 0; gi < NUM_MSI; gi++) begin : g_chk
        // R5: pending only drops through a clear write carrying bit 62
        assert_pend_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.ent[gi].pend && !(pclr_we && w_pend && 32'(reg_idx) == gi) |=> st_q.ent[gi].pend);
        // R2: an accepted write latches pending
        assert_pend_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
            set_pend && 32'(lk_num) == gi && !(pclr_we && 32'(reg_idx) == gi) |=> st_q.ent[gi].pend);
    end
endmodule

// File: rtl/msi_queue_slot.sv
module msi_queue_slot
    import msi_eq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push,
    output logic                  full,
    input  logic                  head_we,
    input  logic                  tail_we,
    input  logic                  cset_we,
    input  logic                  cclr_we,
    input  logic [RING_IDX_W-1:0] w_idx,
    input  logic                  w_en,
    input  logic                  w_e2i,
    input  logic                  w_ovf,
    output logic                  en,
    output logic                  ovf,
    output qstate_e               state,
    output logic [RING_IDX_W-1:0] head,
    output logic [RING_IDX_W-1:0] tail
);
    typedef struct packed {
        logic                  en;
        logic                  ovf;
        qstate_e               st;
        logic [RING_IDX_W-1:0] head;
        logic [RING_IDX_W-1:0] tail;
    } slot_t;

    slot_t                 sl_d, sl_q;
    logic [RING_IDX_W-1:0] tail_inc;

    always_comb begin
        sl_d     = sl_q;
        tail_inc = sl_q.tail + 1'b1;
        full     = (tail_inc == sl_q.head);
        if (push) begin
            if (full) begin
                sl_d.ovf = 1'b1;
                sl_d.st  = QS_ERROR;
            end else begin
                sl_d.tail = tail_inc;
                sl_d.st   = QS_ACTIVE;
            end
        end
        if (tail_we)
            sl_d.tail = w_idx;
        if (head_we) begin
            sl_d.head = w_idx;
            if (sl_d.st == QS_ACTIVE && w_idx == sl_d.tail)
                sl_d.st = QS_IDLE;
        end
        if (cset_we && w_en)
            sl_d.en = 1'b1;
        if (cclr_we) begin
            if (w_en)  sl_d.en  = 1'b0;
            if (w_ovf) sl_d.ovf = 1'b0;
            if (w_e2i && sl_d.st == QS_ERROR)
                sl_d.st = QS_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sl_q      <= '0;
            sl_q.st   <= QS_IDLE;
        end else begin
            sl_q <= sl_d;
        end
    end

    assign en    = sl_q.en;
    assign ovf   = sl_q.ovf;
    assign state = sl_q.st;
    assign head  = sl_q.head;
    assign tail  = sl_q.tail;

    // R8: state is always exactly one of idle/active/error
    assert_state_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(sl_q.st));
    // R2: a push with room advances the tail by one
    assert_tail_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push && !full && !tail_we |=> sl_q.tail == $past(sl_q.tail) + 1'b1);
    // R9: a push into a full ring raises overflow and error
    assert_full_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push && full && !cclr_we |=> sl_q.ovf && sl_q.st == QS_ERROR);
    // R10: error is left only through the control-clear register
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sl_q.st == QS_ERROR && !cclr_we |=> sl_q.st == QS_ERROR);
endmodule

// File: rtl/msi_record_fmt.sv
module msi_record_fmt
    import msi_eq_pkg::*;
#(
    parameter int              QIDX_W    = 3,
    parameter int              MEM_AW    = 48,
    parameter logic [MEM_AW-1:0] BASE_ADDR = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fire,
    input  logic [QIDX_W-1:0]     qsel,
    input  logic [RING_IDX_W-1:0] slot,
    input  logic [15:0]           num,
    input  logic [15:0]           data,
    input  logic [63:0]           addr,
    input  logic [15:0]           rid,
    input  logic                  is64,
    output logic                  wr_valid,
    output logic [MEM_AW-1:0]     wr_addr,
    output logic [REC_W-1:0]      wr_data
);
    typedef struct packed {
        logic              valid;
        logic [MEM_AW-1:0] addr;
        logic [REC_W-1:0]  data;
    } rec_t;

    rec_t rec_d, rec_q;

    always_comb begin
        rec_d       = rec_q;
        rec_d.valid = fire;
        if (fire) begin
            rec_d.addr = BASE_ADDR + (MEM_AW'(qsel) << QUEUE_SHIFT) + (MEM_AW'(slot) << REC_SHIFT);
            rec_d.data = {{(REC_W - 128){1'b0}}, rec_word1(addr, data), rec_word0(is64, addr, rid, num)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign wr_valid = rec_q.valid;
    assign wr_addr  = rec_q.addr;
    assign wr_data  = rec_q.data;

    // R3: a record carries one of the two MSI format/type codes
    assert_fmt_type_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_data[62:56] == 7'h58 || wr_data[62:56] == 7'h78));
    // R3: upper six words are zero
    assert_resv_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_data[REC_W-1:128] == '0);
endmodule

// File: rtl/msi_eq_engine.sv
module msi_eq_engine
    import msi_eq_pkg::*;
#(
    parameter int                NUM_MSI   = 64,
    parameter int                NUM_Q     = 8,
    parameter int                FIRST_Q   = 0,
    parameter int                MEM_AW    = 48,
    parameter logic [MEM_AW-1:0] BASE_ADDR = 48'h0000_4000_0000,
    localparam int               MSI_W     = $clog2(NUM_MSI),
    localparam int               QIDX_W    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    msi_valid,
    input  logic [MSI_W-1:0]        msi_num,
    input  logic [15:0]             msi_data,
    input  logic [63:0]             msi_addr,
    input  logic [15:0]             msi_rid,
    input  logic                    msi_is64,
    input  logic                    reg_we,
    input  logic [REG_AW-1:0]       reg_addr,
    input  logic [63:0]             reg_wdata,
    output logic [63:0]             reg_rdata,
    output logic                    mem_wr_valid,
    output logic [MEM_AW-1:0]       mem_wr_addr,
    output logic [REC_W-1:0]        mem_wr_data,
    output logic [NUM_Q-1:0]        q_irq
);
    rgn_e                  rgn;
    logic [REG_IDX_W-1:0]  ridx;
    logic                  qreg_ok;
    map_ent_t              lk_ent, rd_ent;
    logic                  num_ok, q_in_range, accept, write_ok;
    logic [QNUM_W-1:0]     qlocal;
    logic [QIDX_W-1:0]     qsel;
    logic [NUM_Q-1:0]      q_en, q_ovf, q_full, q_push;
    logic [NUM_Q-1:0]      head_we, tail_we, cset_we, cclr_we;
    qstate_e               q_st   [NUM_Q];
    logic [RING_IDX_W-1:0] q_head [NUM_Q];
    logic [RING_IDX_W-1:0] q_tail [NUM_Q];
    logic [QIDX_W-1:0]     rqsel;

    assign rgn     = rgn_e'(reg_addr[REG_AW-1:REG_IDX_W]);
    assign ridx    = reg_addr[REG_IDX_W-1:0];
    assign qreg_ok = (32'(ridx) < NUM_Q);
    assign rqsel   = ridx[QIDX_W-1:0];

    msi_map_table #(.NUM_MSI(NUM_MSI), .MSI_W(MSI_W)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_num   (msi_num),
        .lk_ent   (lk_ent),
        .set_pend (write_ok),
        .map_we   (reg_we && rgn == RG_MAP),
        .pclr_we  (reg_we && rgn == RG_PCLR),
        .reg_idx  (ridx),
        .w_valid  (reg_wdata[MAP_VALID_BIT]),
        .w_pend   (reg_wdata[MAP_PEND_BIT]),
        .w_qnum   (reg_wdata[QNUM_W-1:0]),
        .rd_ent   (rd_ent)
    );

    always_comb begin
        num_ok     = (32'(msi_num) < NUM_MSI);
        q_in_range = (32'(lk_ent.qnum) >= FIRST_Q) && (32'(lk_ent.qnum) < FIRST_Q + NUM_Q);
        qlocal     = lk_ent.qnum - QNUM_W'(FIRST_Q);
        qsel       = qlocal[QIDX_W-1:0];
        accept     = msi_valid && num_ok && lk_ent.valid && !lk_ent.pend && q_in_range &&
                     q_en[qsel] && q_st[qsel] != QS_ERROR;
        write_ok   = accept && !q_full[qsel];
        for (int i = 0; i < NUM_Q; i++) begin
            q_push[i]  = accept && (32'(qsel) == i);
            head_we[i] = reg_we && rgn == RG_HEAD && 32'(ridx) == i;
            tail_we[i] = reg_we && rgn == RG_TAIL && 32'(ridx) == i;
            cset_we[i] = reg_we && rgn == RG_CSET && 32'(ridx) == i;
            cclr_we[i] = reg_we && rgn == RG_CCLR && 32'(ridx) == i;
        end
    end

    for (genvar gq = 0; gq < NUM_Q; gq++) begin : g_q
        msi_queue_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .push    (q_push[gq]),
            .full    (q_full[gq]),
            .head_we (head_we[gq]),
            .tail_we (tail_we[gq]),
            .cset_we (cset_we[gq]),
            .cclr_we (cclr_we[gq]),
            .w_idx   (reg_wdata[RING_IDX_W-1:0]),
            .w_en    (reg_wdata[CTL_EN_BIT]),
            .w_e2i   (reg_wdata[CTL_E2I_BIT]),
            .w_ovf   (reg_wdata[CTL_OVF_BIT]),
            .en      (q_en[gq]),
            .ovf     (q_ovf[gq]),
            .state   (q_st[gq]),
            .head    (q_head[gq]),
            .tail    (q_tail[gq])
        );
        assign q_irq[gq] = (q_st[gq] == QS_ACTIVE);
    end

    msi_record_fmt #(.QIDX_W(QIDX_W), .MEM_AW(MEM_AW), .BASE_ADDR(BASE_ADDR)) u_fmt (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (write_ok),
        .qsel     (qsel),
        .slot     (q_tail[qsel]),
        .num      (16'(msi_num)),
        .data     (msi_data),
        .addr     (msi_addr),
        .rid      (msi_rid),
        .is64     (msi_is64),
        .wr_valid (mem_wr_valid),
        .wr_addr  (mem_wr_addr),
        .wr_data  (mem_wr_data)
    );

    always_comb begin
        reg_rdata = '0;
        case (rgn)
            RG_MAP: begin
                reg_rdata[MAP_VALID_BIT]  = rd_ent.valid;
                reg_rdata[MAP_PEND_BIT]   = rd_ent.pend;
                reg_rdata[QNUM_W-1:0]     = rd_ent.qnum;
            end
            RG_CSET, RG_CCLR: if (qreg_ok) begin
                reg_rdata[CTL_EN_BIT]  = q_en[rqsel];
                reg_rdata[CTL_OVF_BIT] = q_ovf[rqsel];
            end
            RG_STATE: if (qreg_ok) reg_rdata[2:0] = q_st[rqsel];
            RG_TAIL: if (qreg_ok) begin
                reg_rdata[CTL_OVF_BIT]      = q_ovf[rqsel];
                reg_rdata[RING_IDX_W-1:0]   = q_tail[rqsel];
            end
            RG_HEAD: if (qreg_ok) reg_rdata[RING_IDX_W-1:0] = q_head[rqsel];
            default: reg_rdata = '0;
        endcase
    end

    // R2: every record request answers an MSI presented one cycle earlier
    assert_write_follows_msi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> $past(msi_valid));
    // R4: an MSI aimed at a disabled queue leaves no record
    assert_no_write_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        msi_valid && q_in_range && !q_en[qsel] |=> !mem_wr_valid);
    // R9: a full ring is never written
    assert_no_write_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        msi_valid && q_in_range && q_full[qsel] |=> !mem_wr_valid);
endmodule

// File: tb/tb_msi_eq_engine.sv
module tb_msi_eq_engine;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_MSI = 16;
    localparam int NUM_Q   = 4;
    localparam int FIRST_Q = 2;
    localparam int MEM_AW  = 48;
    localparam logic [47:0] BASE = 48'h0000_8000_0000;
    localparam int MSI_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic msi_valid = 1'b0;
    logic [MSI_W-1:0] msi_num = '0;
    logic [15:0] msi_data = '0;
    logic [63:0] msi_addr = '0;
    logic [15:0] msi_rid = '0;
    logic msi_is64 = 1'b0;
    logic reg_we = 1'b0;
    logic [8:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic mem_wr_valid;
    logic [MEM_AW-1:0] mem_wr_addr;
    logic [511:0] mem_wr_data;
    logic [NUM_Q-1:0] q_irq;

    msi_eq_engine #(.NUM_MSI(NUM_MSI), .NUM_Q(NUM_Q), .FIRST_Q(FIRST_Q),
                    .MEM_AW(MEM_AW), .BASE_ADDR(BASE)) dut (
        .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_num(msi_num),
        .msi_data(msi_data), .msi_addr(msi_addr), .msi_rid(msi_rid), .msi_is64(msi_is64),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .q_irq(q_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    logic [MEM_AW-1:0] exp_addr_q [$];
    logic [511:0]      exp_data_q [$];

    localparam logic [2:0] R_MAP = 3'd0, R_PCLR = 3'd1, R_CSET = 3'd2, R_CCLR = 3'd3,
                           R_STATE = 3'd4, R_TAIL = 3'd5, R_HEAD = 3'd6;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] rgn, input int idx, input logic [63:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = {rgn, 6'(idx)}; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic reg_chk(input logic [2:0] rgn, input int idx, input logic [63:0] exp, input string tag);
        reg_addr = {rgn, 6'(idx)};
        #1;
        check(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    function automatic logic [511:0] exp_rec(input int num, input logic [15:0] data,
                                             input logic [63:0] addr, input logic [15:0] rid, input bit is64);
        logic [63:0] w0, w1;
        w0 = {1'b0, (is64 ? 7'h78 : 7'h58), 10'd1, addr[15:2], rid, 16'(num)};
        w1 = {addr[63:16], data};
        return {384'b0, w1, w0};
    endfunction

    // driver: presents one MSI and pushes its expected record when one is due
    task automatic send_msi(input int num, input logic [15:0] data, input logic [63:0] addr,
                            input logic [15:0] rid, input bit is64,
                            input bit exp_wr, input int lq, input int slot);
        @(negedge clk);
        msi_valid = 1'b1; msi_num = MSI_W'(num); msi_data = data;
        msi_addr = addr; msi_rid = rid; msi_is64 = is64;
        if (exp_wr) begin
            exp_addr_q.push_back(BASE + (48'(lq) << 13) + (48'(slot) << 6));
            exp_data_q.push_back(exp_rec(num, data, addr, rid, is64));
        end
        @(negedge clk);
        msi_valid = 1'b0;
    endtask

    // monitor: compares each record request against the scoreboard
    always @(negedge clk) begin
        if (rst_n && mem_wr_valid) begin
            if (exp_addr_q.size() == 0) begin
                check(1'b0, "R4 unexpected record", 64'(mem_wr_addr), 64'h0);
            end else begin
                logic [MEM_AW-1:0] ea;
                logic [511:0] ed;
                ea = exp_addr_q.pop_front();
                ed = exp_data_q.pop_front();
                check(mem_wr_addr == ea, "R2 record address", 64'(mem_wr_addr), 64'(ea));
                check(mem_wr_data[127:0] == ed[127:0], "R3 record words 0/1",
                      mem_wr_data[63:0], ed[63:0]);
                check(mem_wr_data[511:128] == '0, "R3 reserved words zero",
                      mem_wr_data[191:128], 64'h0);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    localparam logic [63:0] EN  = 64'h1 << 44;
    localparam logic [63:0] E2I = 64'h1 << 47;
    localparam logic [63:0] OVF = 64'h1 << 57;
    localparam logic [63:0] PND = 64'h1 << 62;
    localparam logic [63:0] VLD = 64'h1 << 63;
    localparam logic [63:0] A32 = 64'h0000_0000_FEE0_1234;
    localparam logic [63:0] A64 = 64'h0012_3456_789A_BCD8;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int q = 0; q < NUM_Q; q++) begin
            reg_chk(R_STATE, q, 64'd1, "R1 state idle");
            reg_chk(R_TAIL, q, 64'd0, "R1 tail zero");
            reg_chk(R_HEAD, q, 64'd0, "R1 head zero");
            reg_chk(R_CSET, q, 64'd0, "R1 control zero");
        end
        reg_chk(R_MAP, 5, 64'd0, "R1 map zero");
        check(q_irq == '0, "R1 irq low", 64'(q_irq), 64'h0);
        check(mem_wr_valid == 1'b0, "R1 no write", 64'(mem_wr_valid), 64'h0);

        // R6 R12 mapping writes
        reg_wr(R_MAP, 3, VLD | 64'd2);
        reg_wr(R_MAP, 4, VLD | 64'd5);
        reg_wr(R_MAP, 5, VLD | 64'd7);
        reg_wr(R_MAP, 6, 64'd2);
        reg_wr(R_MAP, 8, VLD | 64'd3);
        reg_wr(R_MAP, 7, VLD | PND | 64'd4);
        reg_chk(R_MAP, 3, VLD | 64'd2, "R6 map store");
        reg_chk(R_MAP, 7, VLD | 64'd4, "R6 pending not writable");

        // R7 enables
        reg_wr(R_CSET, 0, EN);
        reg_wr(R_CSET, 3, EN);
        reg_wr(R_CSET, 1, 64'h1 << 43);
        reg_chk(R_CSET, 0, EN, "R7 enable set");
        reg_chk(R_CCLR, 1, 64'd0, "R7 other bit no effect");

        // R2 R3 first 32-bit MSI
        send_msi(3, 16'hA5A5, A32, 16'h0108, 1'b0, 1'b1, 0, 0);
        reg_chk(R_TAIL, 0, 64'd1, "R2 tail advanced");
        reg_chk(R_MAP, 3, VLD | PND | 64'd2, "R2 pending set");
        reg_chk(R_STATE, 0, 64'd2, "R8 state active");
        check(q_irq == 4'b0001, "R8 irq raised", 64'(q_irq), 64'h1);

        // R4 pending blocks repeat
        send_msi(3, 16'h1111, A32, 16'h0108, 1'b0, 1'b0, 0, 0);
        reg_chk(R_TAIL, 0, 64'd1, "R4 pending drop tail");

        // R5 clear register
        reg_wr(R_PCLR, 3, 64'h1 << 61);
        reg_chk(R_MAP, 3, VLD | PND | 64'd2, "R5 clear without bit62");
        reg_wr(R_PCLR, 3, PND);
        reg_chk(R_MAP, 3, VLD | 64'd2, "R5 clear with bit62");
        send_msi(3, 16'h2222, A64, 16'h0210, 1'b1, 1'b1, 0, 1);
        reg_chk(R_TAIL, 0, 64'd2, "R2 second tail");

        // R4 drop cases
        send_msi(5, 16'h3333, A32, 16'h0001, 1'b0, 1'b0, 0, 0);
        send_msi(6, 16'h4444, A32, 16'h0001, 1'b0, 1'b0, 0, 0);
        send_msi(8, 16'h5555, A32, 16'h0001, 1'b0, 1'b0, 0, 0);
        reg_chk(R_TAIL, 0, 64'd2, "R4 invalid/out-of-range drop");
        reg_chk(R_TAIL, 1, 64'd0, "R4 disabled queue drop");
        reg_chk(R_MAP, 8, VLD | 64'd3, "R4 drop leaves pending clear");

        // R2 queue offset for local queue 3
        send_msi(4, 16'h6666, A64, 16'hBEEF, 1'b1, 1'b1, 3, 0);
        reg_chk(R_TAIL, 3, 64'd1, "R2 queue 3 tail");

        // R8 head write returns to idle
        reg_wr(R_HEAD, 0, 64'd2);
        reg_chk(R_STATE, 0, 64'd1, "R8 head==tail idle");
        check(q_irq == 4'b1000, "R8 irq follows active", 64'(q_irq), 64'h8);

        // R9 overflow
        reg_wr(R_HEAD, 3, 64'd2);
        reg_chk(R_STATE, 3, 64'd2, "R8 head!=tail stays active");
        reg_wr(R_PCLR, 4, PND);
        send_msi(4, 16'h7777, A32, 16'h0001, 1'b0, 1'b0, 3, 0);
        reg_chk(R_TAIL, 3, OVF | 64'd1, "R9 overflow flagged");
        reg_chk(R_STATE, 3, 64'd4, "R9 error state");
        reg_chk(R_MAP, 4, VLD | 64'd5, "R9 pending stays clear");
        check(q_irq[3] == 1'b0, "R9 irq low in error", 64'(q_irq), 64'h0);
        reg_wr(R_HEAD, 3, 64'd5);
        send_msi(4, 16'h8888, A32, 16'h0001, 1'b0, 1'b0, 3, 0);
        reg_chk(R_TAIL, 3, OVF | 64'd1, "R9 error drops MSI");

        // R10 recovery
        reg_wr(R_CCLR, 3, E2I);
        reg_chk(R_STATE, 3, 64'd1, "R10 error to idle");
        reg_chk(R_CCLR, 3, EN | OVF, "R10 overflow kept");
        reg_wr(R_CCLR, 3, OVF);
        reg_chk(R_TAIL, 3, 64'd1, "R10 overflow cleared");
        send_msi(4, 16'h9999, A32, 16'h0042, 1'b0, 1'b1, 3, 1);
        reg_chk(R_TAIL, 3, 64'd2, "R10 accepts after recovery");

        // R11 wrap
        reg_wr(R_TAIL, 0, 64'd127);
        reg_wr(R_HEAD, 0, 64'd10);
        reg_wr(R_PCLR, 3, PND);
        send_msi(3, 16'hCAFE, A64, 16'h0300, 1'b1, 1'b1, 0, 127);
        reg_chk(R_TAIL, 0, 64'd0, "R11 tail wrap");

        // R7 disable
        reg_wr(R_CCLR, 0, EN);
        reg_chk(R_CSET, 0, 64'd0, "R7 enable cleared");
        reg_wr(R_PCLR, 3, PND);
        send_msi(3, 16'hDEAD, A32, 16'h0300, 1'b0, 1'b0, 0, 0);
        reg_chk(R_TAIL, 0, 64'd0, "R7 disabled drop");

        repeat (3) @(negedge clk);
        check(exp_addr_q.size() == 0, "R2 all expected records seen",
              64'(exp_addr_q.size()), 64'h0);
        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule